// File: doc/BRIEF.md
# Call and Control-Operation Sequencer

This block sits beside a small processor's decoder and carries out the subroutine call and the eight control operations selected by a 3-bit code. It holds a hardware return-address stack that both subroutine calls and interrupts use. It also holds a four-value execution-mode register and flags for the boot (BIOS) program, halt, shutdown, end of program and interrupt service. From these it computes the program counter the core fetches from next.

Each cycle the core presents its current PC. When the decode strobe is high, it also presents either a call or a control code. The block returns `next_pc_o` combinationally from these inputs and from its current state, and updates its state at the next rising clock edge. With no strobe and no interrupt, the PC holds. An interrupt request is served ahead of an instruction in the same cycle. Stack misuse never corrupts the stack: it raises a sticky error, and the faulting operation falls through to the next sequential address.

Top module: `ctl_call_unit`

## Requirements
- R1: After reset, halted_o, shutdown_o, done_o, irq_active_o, ovf_err_o and unf_err_o are 0, mode_o is 0 and bios_o is 1.
- R2: An executed call (issue_i=1, op_call_i=1) with the stack not full gives next_pc_o = reg_a_i[PC_W-1:0] and pushes pc_i+1.
- R3: An executed return (code 2) with the stack not empty gives next_pc_o equal to the most recently pushed address, in last-in first-out order.
- R4: The stack holds DEPTH (default 8) addresses. A call when it is full leaves the stack unchanged, gives next_pc_o = pc_i+1, and sets ovf_err_o, which stays set until reset.
- R5: A return or end-interrupt when the stack is empty leaves it unchanged, gives next_pc_o = pc_i+1, and sets unf_err_o, which stays set until reset.
- R6: Code 6 loads mode_o from reg_a_i[1:0] (0 normal, 1 floating point, 2 SIMD, 3 immediate) and gives next_pc_o = pc_i+1. No other operation changes mode_o.
- R7: Code 3 does nothing except give next_pc_o = pc_i+1. With issue_i=0 and no interrupt taken, next_pc_o = pc_i.
- R8: Code 5 gives next_pc_o = pc_i+1 and sets halted_o. While halted, next_pc_o = pc_i and issued operations are ignored, until reset or a taken interrupt.
- R9: An interrupt is taken when irq_i=1, irq_active_o=0, shutdown_o=0, done_o=0 and the stack is not full. A taken interrupt pushes pc_i, gives next_pc_o = IRQ_VEC (default 0xF0), sets irq_active_o and clears halted_o. While irq_active_o=1, irq_i is ignored.
- R10: Code 4 pops the stack into next_pc_o and clears irq_active_o.
- R11: Code 1 gives next_pc_o = 0 and clears bios_o.
- R12: Code 0 gives next_pc_o = pc_i+1 and sets shutdown_o. From then on, next_pc_o = pc_i and both issue_i and irq_i are ignored until reset.
- R13: Code 7 gives next_pc_o = pc_i+1 and sets done_o. From then on, next_pc_o = pc_i and both issue_i and irq_i are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Decode strobe: an operation is presented this cycle |
| op_call_i | input | 1 | 1 = call, 0 = control operation given by ctl_code_i |
| ctl_code_i | input | 3 | Control operation code |
| reg_a_i | input | DATA_W | Register A value: call target or new mode |
| pc_i | input | PC_W | Current program counter |
| irq_i | input | 1 | Interrupt request level |
| next_pc_o | output | PC_W | Next program counter |
| halted_o | output | 1 | Halted, waiting for an interrupt |
| shutdown_o | output | 1 | Shut down until reset |
| done_o | output | 1 | End of program reached |
| mode_o | output | 2 | Current execution mode |
| bios_o | output | 1 | Boot program still active |
| irq_active_o | output | 1 | Interrupt service in progress |
| ovf_err_o | output | 1 | Sticky stack overflow error |
| unf_err_o | output | 1 | Sticky stack underflow error |

## Verification
The checker watches, on every cycle, the freeze of the PC while halted, shut down or finished. It also checks that the two error flags and the shutdown flag are sticky, that the mode changes only after a set-mode strobe, and that interrupt entry and boot exit land on their fixed addresses. The directed scenarios are needed for the data path through the stack: the last-in first-out order across a full stack, the fall-through at overflow and underflow, and the return address an interrupt leaves behind after waking a halted core.

// File: rtl/ctl_call_pkg.sv
package ctl_call_pkg;

   typedef enum logic [2:0] {
      OP_SHUTDOWN  = 3'd0,
      OP_EXIT_BIOS = 3'd1,
      OP_RETURN    = 3'd2,
      OP_NOP       = 3'd3,
      OP_END_IRQ   = 3'd4,
      OP_HALT      = 3'd5,
      OP_SET_MODE  = 3'd6,
      OP_END_FILE  = 3'd7
   } ctl_op_e;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_FLOAT  = 2'd1,
      MODE_VECTOR = 2'd2,
      MODE_IMM    = 2'd3
   } exec_mode_e;

   // one bit per action, at most one set
   typedef struct packed {
      logic call;
      logic ret;
      logic iret;
      logic halt;
      logic shut;
      logic bios_exit;
      logic set_mode;
      logic end_file;
   } ctl_act_t;

endpackage

// File: rtl/ctl_op_decode.sv
module ctl_op_decode
   import ctl_call_pkg::*;
(
   input  logic       exec_i,
   input  logic       is_call_i,
   input  logic [2:0] code_i,
   output ctl_act_t   act_o
);

   always_comb begin
      act_o = '0;
      if (exec_i) begin
         if (is_call_i) begin
            act_o.call = 1'b1;
         end else begin
            unique case (ctl_op_e'(code_i))
               OP_SHUTDOWN:  act_o.shut      = 1'b1;
               OP_EXIT_BIOS: act_o.bios_exit = 1'b1;
               OP_RETURN:    act_o.ret       = 1'b1;
               OP_END_IRQ:   act_o.iret      = 1'b1;
               OP_HALT:      act_o.halt      = 1'b1;
               OP_SET_MODE:  act_o.set_mode  = 1'b1;
               OP_END_FILE:  act_o.end_file  = 1'b1;
               default:      act_o           = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/ctl_ret_stack.sv
module ctl_ret_stack #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] top_o,
   output logic         full_o,
   output logic         empty_o
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0]   cnt_q;
   logic [DEPTH*W-1:0] flat;
   logic               do_push;
   logic               do_pop;

   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o && !push_i;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (do_push) cnt_q <= cnt_q + 1'b1;
      else if (do_pop)  cnt_q <= cnt_q - 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                q <= '0;
         else if (do_push && cnt_q == CNT_W'(g))    q <= din_i;
      end
      assign flat[g*W +: W] = q;
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CNT_W'(i + 1) == cnt_q) top_o = flat[i*W +: W];
      end
   end

endmodule

// File: rtl/ctl_call_unit.sv
module ctl_call_unit
   import ctl_call_pkg::*;
#(
   parameter int unsigned PC_W    = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned IRQ_VEC = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              op_call_i,
   input  logic [2:0]        ctl_code_i,
   input  logic [DATA_W-1:0] reg_a_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              irq_i,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              halted_o,
   output logic              shutdown_o,
   output logic              done_o,
   output logic [1:0]        mode_o,
   output logic              bios_o,
   output logic              irq_active_o,
   output logic              ovf_err_o,
   output logic              unf_err_o
);

   localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

   if (DEPTH < 1) begin : g_bad_depth
      $error("ctl_call_unit: DEPTH must be at least 1");
   end
   if (DATA_W < PC_W) begin : g_bad_width
      $error("ctl_call_unit: DATA_W must cover PC_W");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("ctl_call_unit: PC_W must be at least 2");
   end

   logic            halted_q, shut_q, done_q, irq_act_q, bios_q, ovf_q, unf_q;
   exec_mode_e      mode_q;
   logic            frozen, irq_req, irq_take, irq_refused, exec;
   logic            st_full, st_empty, st_push, st_pop;
   logic [PC_W-1:0] st_top, st_din, pc_inc;
   ctl_act_t        act;

   assign frozen      = shut_q | done_q;
   assign irq_req     = irq_i & ~irq_act_q & ~frozen;
   assign irq_take    = irq_req & ~st_full;
   assign irq_refused = irq_req & st_full;
   assign exec        = issue_i & ~halted_q & ~frozen & ~irq_take;
   assign pc_inc      = pc_i + 1'b1;

   ctl_op_decode u_dec (
      .exec_i    (exec),
      .is_call_i (op_call_i),
      .code_i    (ctl_code_i),
      .act_o     (act)
   );

   assign st_push = irq_take | (act.call & ~st_full);
   assign st_pop  = (act.ret | act.iret) & ~st_empty;
   assign st_din  = irq_take ? pc_i : pc_inc;

   ctl_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (st_push),
      .pop_i   (st_pop),
      .din_i   (st_din),
      .top_o   (st_top),
      .full_o  (st_full),
      .empty_o (st_empty)
   );

   always_comb begin
      next_pc_o = pc_i;
      if (irq_take) begin
         next_pc_o = VEC;
      end else if (exec) begin
         next_pc_o = pc_inc;
         if (act.call && !st_full)                 next_pc_o = reg_a_i[PC_W-1:0];
         if ((act.ret || act.iret) && !st_empty)   next_pc_o = st_top;
         if (act.bios_exit)                        next_pc_o = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q  <= 1'b0;
         shut_q    <= 1'b0;
         done_q    <= 1'b0;
         irq_act_q <= 1'b0;
         bios_q    <= 1'b1;
         mode_q    <= MODE_NORMAL;
         ovf_q     <= 1'b0;
         unf_q     <= 1'b0;
      end else begin
         if (irq_take)               halted_q  <= 1'b0;
         else if (act.halt)          halted_q  <= 1'b1;
         if (act.shut)               shut_q    <= 1'b1;
         if (act.end_file)           done_q    <= 1'b1;
         if (irq_take)               irq_act_q <= 1'b1;
         else if (act.iret)          irq_act_q <= 1'b0;
         if (act.bios_exit)          bios_q    <= 1'b0;
         if (act.set_mode)           mode_q    <= exec_mode_e'(reg_a_i[1:0]);
         if (irq_refused || (act.call && st_full))
            ovf_q <= 1'b1;
         if ((act.ret || act.iret) && st_empty)
            unf_q <= 1'b1;
      end
   end

   assign halted_o     = halted_q;
   assign shutdown_o   = shut_q;
   assign done_o       = done_q;
   assign mode_o       = mode_q;
   assign bios_o       = bios_q;
   assign irq_active_o = irq_act_q;
   assign ovf_err_o    = ovf_q;
   assign unf_err_o    = unf_q;

endmodule

// File: rtl/ctl_call_unit_chk.sv
module ctl_call_unit_chk #(
   parameter int unsigned PC_W    = 8,
   parameter int unsigned IRQ_VEC = 'hF0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue_i,
   input logic            op_call_i,
   input logic [2:0]      ctl_code_i,
   input logic [PC_W-1:0] pc_i,
   input logic            irq_i,
   input logic [PC_W-1:0] next_pc_o,
   input logic            halted_o,
   input logic            shutdown_o,
   input logic            done_o,
   input logic [1:0]      mode_o,
   input logic            bios_o,
   input logic            irq_active_o,
   input logic            ovf_err_o,
   input logic            unf_err_o
);

   localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err_o |=> ovf_err_o); // R4
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err_o |=> unf_err_o); // R5
   AST_MODE_ONLY_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_i && !op_call_i && ctl_code_i == 3'd6) |=> $stable(mode_o)); // R6
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && !irq_i) |-> next_pc_o == pc_i); // R8
   AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_active_o) |-> $past(next_pc_o) == VEC); // R9
   AST_BIOS_EXIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bios_o) |-> $past(next_pc_o) == '0); // R11
   AST_SHUTDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |=> shutdown_o); // R12
   AST_SHUTDOWN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |-> (next_pc_o == pc_i && !$rose(irq_active_o))); // R12
   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> next_pc_o == pc_i); // R13

endmodule

bind ctl_call_unit ctl_call_unit_chk #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_i      (issue_i),
   .op_call_i    (op_call_i),
   .ctl_code_i   (ctl_code_i),
   .pc_i         (pc_i),
   .irq_i        (irq_i),
   .next_pc_o    (next_pc_o),
   .halted_o     (halted_o),
   .shutdown_o   (shutdown_o),
   .done_o       (done_o),
   .mode_o       (mode_o),
   .bios_o       (bios_o),
   .irq_active_o (irq_active_o),
   .ovf_err_o    (ovf_err_o),
   .unf_err_o    (unf_err_o)
);

// File: tb/ctl_call_unit_tb_top.sv
module ctl_call_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue_i = 1'b0;
   logic       op_call_i = 1'b0;
   logic [2:0] ctl_code_i = 3'd0;
   logic [7:0] reg_a_i = 8'd0;
   logic [7:0] pc_i = 8'd0;
   logic       irq_i = 1'b0;
   logic [7:0] next_pc_o;
   logic       halted_o, shutdown_o, done_o, bios_o, irq_active_o, ovf_err_o, unf_err_o;
   logic [1:0] mode_o;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   ctl_call_unit dut_i (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_call_i(op_call_i),
      .ctl_code_i(ctl_code_i), .reg_a_i(reg_a_i), .pc_i(pc_i), .irq_i(irq_i),
      .next_pc_o(next_pc_o), .halted_o(halted_o), .shutdown_o(shutdown_o),
      .done_o(done_o), .mode_o(mode_o), .bios_o(bios_o),
      .irq_active_o(irq_active_o), .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // drive inputs just after an edge, then let combinational paths settle
   task automatic drv(input logic iss, input logic cl, input logic [2:0] code,
                      input logic [7:0] a, input logic [7:0] pc, input logic irq);
      issue_i = iss; op_call_i = cl; ctl_code_i = code;
      reg_a_i = a; pc_i = pc; irq_i = irq;
      #2;
   endtask

   task automatic do_reset();
      drv(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 halted", 32'(halted_o), 0);
      chk("R1 shutdown", 32'(shutdown_o), 0);
      chk("R1 done", 32'(done_o), 0);
      chk("R1 irq_active", 32'(irq_active_o), 0);
      chk("R1 errors", 32'({ovf_err_o, unf_err_o}), 0);
      chk("R1 mode", 32'(mode_o), 0);
      chk("R1 bios", 32'(bios_o), 1);
      drv(1'b0, 1'b0, 3'd3, 8'h00, 8'h37, 1'b0);
      chk("R7 idle hold", 32'(next_pc_o), 32'h37);
   endtask

   task automatic t_call_return();
      do_reset();
      drv(1'b1, 1'b1, 3'd0, 8'h40, 8'h10, 1'b0);
      chk("R2 call target", 32'(next_pc_o), 32'h40);
      tick();
      drv(1'b1, 1'b0, 3'd2, 8'h00, 8'h40, 1'b0);
      chk("R3 return addr", 32'(next_pc_o), 32'h11);
      tick();
      drv(1'b1, 1'b0, 3'd2, 8'h00, 8'h41, 1'b0);
      chk("R5 underflow fallthrough", 32'(next_pc_o), 32'h42);
      tick();
      drv(1'b0, 1'b0, 3'd0, 8'h00, 8'h42, 1'b0);
      chk("R5 unf_err set", 32'(unf_err_o), 1);
      tick();
      chk("R5 unf_err sticky", 32'(unf_err_o), 1);
   endtask

   task automatic t_stack_depth();
      do_reset();
      for (int i = 0; i < 8; i++) begin
         drv(1'b1, 1'b1, 3'd0, 8'h80 + 8'(i), 8'h20 + 8'(i), 1'b0);
         tick();
      end
      drv(1'b1, 1'b1, 3'd0, 8'h99, 8'h30, 1'b0);
      chk("R4 full call falls through", 32'(next_pc_o), 32'h31);
      tick();
      chk("R4 ovf_err set", 32'(ovf_err_o), 1);
      for (int i = 7; i >= 0; i--) begin
         drv(1'b1, 1'b0, 3'd2, 8'h00, 8'h60, 1'b0);
         chk("R3 R4 LIFO order", 32'(next_pc_o), 32'h21 + 32'(i));
         tick();
      end
      chk("R5 no underflow yet", 32'(unf_err_o), 0);
      drv(1'b1, 1'b0, 3'd4, 8'h00, 8'h60, 1'b0);
      chk("R5 empty end-irq falls through", 32'(next_pc_o), 32'h61);
      tick();
      chk("R5 unf_err after end-irq", 32'(unf_err_o), 1);
   endtask

   task automatic t_mode_nop();
      do_reset();
      drv(1'b1, 1'b0, 3'd6, 8'hFE, 8'h05, 1'b0);
      chk("R6 set-mode pc", 32'(next_pc_o), 32'h06);
      tick();
      chk("R6 mode from a[1:0]", 32'(mode_o), 2);
      drv(1'b1, 1'b0, 3'd3, 8'h01, 8'h06, 1'b0);
      chk("R7 nop pc", 32'(next_pc_o), 32'h07);
      tick();
      chk("R7 nop keeps mode", 32'(mode_o), 2);
      drv(1'b1, 1'b0, 3'd6, 8'h03, 8'h07, 1'b0);
      tick();
      chk("R6 immediate mode", 32'(mode_o), 3);
   endtask

   task automatic t_bios();
      do_reset();
      drv(1'b1, 1'b0, 3'd1, 8'h00, 8'h2C, 1'b0);
      chk("R11 exit pc zero", 32'(next_pc_o), 0);
      tick();
      chk("R11 bios cleared", 32'(bios_o), 0);
   endtask

   task automatic t_halt_irq();
      do_reset();
      drv(1'b1, 1'b0, 3'd5, 8'h00, 8'h50, 1'b0);
      chk("R8 halt pc", 32'(next_pc_o), 32'h51);
      tick();
      chk("R8 halted", 32'(halted_o), 1);
      drv(1'b1, 1'b0, 3'd6, 8'h01, 8'h51, 1'b0);
      chk("R8 frozen", 32'(next_pc_o), 32'h51);
      tick();
      chk("R8 issue ignored", 32'(mode_o), 0);
      drv(1'b0, 1'b0, 3'd0, 8'h00, 8'h51, 1'b1);
      chk("R9 vector", 32'(next_pc_o), 32'hF0);
      tick();
      chk("R9 active and awake", 32'({irq_active_o, halted_o}), 32'b10);
      drv(1'b1, 1'b0, 3'd3, 8'h00, 8'hF0, 1'b1);
      chk("R9 nested request ignored", 32'(next_pc_o), 32'hF1);
      tick();
      drv(1'b1, 1'b0, 3'd4, 8'h00, 8'hF1, 1'b0);
      chk("R10 resume addr", 32'(next_pc_o), 32'h51);
      tick();
      chk("R10 active cleared", 32'(irq_active_o), 0);
   endtask

   task automatic t_shutdown();
      do_reset();
      drv(1'b1, 1'b0, 3'd0, 8'h00, 8'h60, 1'b0);
      chk("R12 shutdown pc", 32'(next_pc_o), 32'h61);
      tick();
      chk("R12 shutdown set", 32'(shutdown_o), 1);
      drv(1'b1, 1'b1, 3'd0, 8'h44, 8'h61, 1'b1);
      chk("R12 frozen", 32'(next_pc_o), 32'h61);
      tick();
      chk("R12 irq ignored", 32'(irq_active_o), 0);
   endtask

   task automatic t_end_file();
      do_reset();
      drv(1'b1, 1'b0, 3'd7, 8'h00, 8'h70, 1'b0);
      chk("R13 eof pc", 32'(next_pc_o), 32'h71);
      tick();
      chk("R13 done set", 32'(done_o), 1);
      drv(1'b1, 1'b0, 3'd1, 8'h00, 8'h71, 1'b1);
      chk("R13 frozen", 32'(next_pc_o), 32'h71);
      tick();
      chk("R13 irq and issue ignored", 32'({irq_active_o, bios_o}), 32'b01);
   endtask

   initial begin
      t_reset();
      t_call_return();
      t_stack_depth();
      t_mode_nop();
      t_bios();
      t_halt_irq();
      t_shutdown();
      t_end_file();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule